// File: doc/BRIEF.md
# Receive Message Queue with Hidden Fill Slot

This block holds received bus frames until the host consumes them. Its storage is a ring of message slots, each one record of up to fifteen bytes: control bits, a standard or extended identifier, and payload. One slot is always the fill slot. The receiver writes a frame into it one byte at a time, and the host can never see it. The oldest stored message sits in the host slot, which the host reads through one fixed byte window. The window's address range never moves, whatever physical slot backs it.

At the end of a frame the receiver pulses either a commit strobe or a discard strobe. It pulses commit when the frame was received cleanly and passed filtering, and discard when the frame was bad or was rejected. A commit turns the fill slot into the newest queued entry by moving pointers, so no bytes are copied. A discard rewinds the byte pointer and leaves the queue untouched. The host reads the host slot and then pulses a write-1-to-clear release on the receive-full flag. The next queued message then takes its place. If every storable slot is occupied when a commit arrives, the frame is lost and a sticky overrun flag records it.

Top module: `rx_msg_queue`

## Requirements
- R1: After reset, rx_full_o and overrun_o are 0 and host_rdata_o reads 0 at every address.
- R2: Each rx_we_i cycle stores rx_wdata_i at the next byte offset of the fill slot, starting at offset 0 after reset, commit or discard. Writes past offset 14 are ignored, so a longer frame keeps its first 15 bytes.
- R3: Writes into the fill slot never change host_rdata_o or rx_full_o while the frame is still open.
- R4: A commit (rx_commit_i with rx_abort_i low) appends the frame to the queue. rx_full_o is 1 from the cycle after the commit, and host_rdata_o at address k shows byte k of the oldest stored message.
- R5: A discard (rx_abort_i) leaves the queue and flags unchanged and rewinds the fill slot to offset 0. Discard takes priority over a commit in the same cycle.
- R6: A release (host_clr_i while rx_full_o is 1) removes the oldest message. rx_full_o stays 1 if another message is queued and drops to 0 otherwise. host_clr_i while rx_full_o is 0 has no effect.
- R7: The queue stores at most NUM_BUFS-1 messages (4 by default). A commit arriving when it is full and no release is made in the same cycle is dropped, leaving the stored messages unchanged. overrun_o is then set and remains 1 until reset.
- R8: A commit and a release in the same cycle both take effect, even when the queue was full.
- R9: host_rdata_o is 0 whenever rx_full_o is 0, and for any address of 15 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_we_i | input | 1 | Receiver byte write strobe |
| rx_wdata_i | input | 8 | Receiver byte |
| rx_commit_i | input | 1 | Frame valid and accepted: commit fill slot |
| rx_abort_i | input | 1 | Frame bad or rejected: discard fill slot |
| host_addr_i | input | 4 | Byte offset within the host window |
| host_rdata_o | output | 8 | Byte of the oldest stored message |
| host_clr_i | input | 1 | Write-1-to-clear of the receive-full flag (release) |
| rx_full_o | output | 1 | Host slot holds a valid message |
| overrun_o | output | 1 | Sticky: a committed frame was lost |

## Verification
The bench uses the defaults of five slots and fifteen-byte records. With those values the slot pointers wrap at a count that is not a power of two, and the byte index saturates one short of its 4-bit range. The queue also reaches full occupancy within a few frames, so the random mix of commits, discards, releases and commit-with-release repeatedly crosses the full boundary and the pointer wrap. Frame lengths of sixteen and seventeen bytes exercise the ignored tail writes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DEF_NUM_BUFS  = 5;
  localparam int unsigned DEF_MSG_BYTES = 15;
  localparam int unsigned DEF_DATA_W    = 8;

  typedef enum logic [1:0] {
    Q_HOLD = 2'b00,
    Q_PUSH = 2'b01,
    Q_POP  = 2'b10,
    Q_SWAP = 2'b11
  } q_op_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned NUM_BUFS  = DEF_NUM_BUFS,
  parameter int unsigned MSG_BYTES = DEF_MSG_BYTES,
  parameter int unsigned SLOT_W    = $clog2(NUM_BUFS),
  parameter int unsigned IDX_W     = $clog2(MSG_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              release_i,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              byte_en_o,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic              full_o,
  output logic              overrun_o
);
  localparam int unsigned CAP   = NUM_BUFS - 1;
  localparam int unsigned CNT_W = $clog2(NUM_BUFS + 1);

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(NUM_BUFS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             do_rel, do_commit, do_push, do_drop;
  q_op_e            op;

  assign do_rel    = release_i && (cnt_q != '0);
  assign do_commit = commit_i && !abort_i;
  // a release in the same cycle frees a slot, so the commit still fits
  assign do_push   = do_commit && ((cnt_q < CNT_W'(CAP)) || do_rel);
  assign do_drop   = do_commit && !do_push;
  assign op        = q_op_e'({do_rel, do_push});
  assign byte_en_o = we_i && (byte_idx_o < IDX_W'(MSG_BYTES));
  assign full_o    = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      wr_slot_o  <= '0;
      rd_slot_o  <= '0;
      byte_idx_o <= '0;
      overrun_o  <= 1'b0;
    end else begin
      if (commit_i || abort_i) byte_idx_o <= '0;
      else if (byte_en_o)      byte_idx_o <= byte_idx_o + 1'b1;
      if (do_push) wr_slot_o <= bump(wr_slot_o);
      if (do_rel)  rd_slot_o <= bump(rd_slot_o);
      unique case (op)
        Q_PUSH:  cnt_q <= cnt_q + 1'b1;
        Q_POP:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (do_drop) overrun_o <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CAP)); // R7
  AST_DROP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !abort_i && !release_i && cnt_q == CNT_W'(CAP))
      |=> ($stable(cnt_q) && $stable(wr_slot_o) && overrun_o)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R7
  AST_ABORT_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (byte_idx_o == '0 && $stable(wr_slot_o) && $stable(cnt_q))); // R5
  AST_SWAP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !abort_i && release_i && full_o) |=> $stable(cnt_q)); // R8
  AST_IDX_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_idx_o <= IDX_W'(MSG_BYTES)); // R2
  AST_REL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !full_o) |=> $stable(rd_slot_o)); // R6
endmodule

// File: rtl/rxq_bank.sv
module rxq_bank
  import rxq_pkg::*;
#(
  parameter int unsigned NUM_BUFS  = DEF_NUM_BUFS,
  parameter int unsigned MSG_BYTES = DEF_MSG_BYTES,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned SLOT_W    = $clog2(NUM_BUFS),
  parameter int unsigned IDX_W     = $clog2(MSG_BYTES + 1),
  parameter int unsigned ADDR_W    = $clog2(MSG_BYTES)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_rd [NUM_BUFS];
  logic              addr_ok;

  assign addr_ok = (32'(rd_addr_i) < MSG_BYTES);

  for (genvar s = 0; s < NUM_BUFS; s++) begin : g_slot
    logic [DATA_W-1:0] cells [MSG_BYTES];
    always_ff @(posedge clk_i) begin
      if (we_i && wr_slot_i == SLOT_W'(s))
        cells[wr_idx_i[ADDR_W-1:0]] <= wdata_i;
    end
    assign slot_rd[s] = addr_ok ? cells[rd_addr_i] : '0;
  end

  assign rdata_o = (rd_en_i && addr_ok) ? slot_rd[rd_slot_i] : '0;
endmodule

// File: rtl/rx_msg_queue.sv
module rx_msg_queue
  import rxq_pkg::*;
#(
  parameter int unsigned NUM_BUFS  = DEF_NUM_BUFS,
  parameter int unsigned MSG_BYTES = DEF_MSG_BYTES,
  parameter int unsigned DATA_W    = DEF_DATA_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rx_we_i,
  input  logic [DATA_W-1:0]            rx_wdata_i,
  input  logic                         rx_commit_i,
  input  logic                         rx_abort_i,
  input  logic [$clog2(MSG_BYTES)-1:0] host_addr_i,
  output logic [DATA_W-1:0]            host_rdata_o,
  input  logic                         host_clr_i,
  output logic                         rx_full_o,
  output logic                         overrun_o
);
  localparam int unsigned SLOT_W = $clog2(NUM_BUFS);
  localparam int unsigned IDX_W  = $clog2(MSG_BYTES + 1);
  localparam int unsigned ADDR_W = $clog2(MSG_BYTES);

  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  byte_idx;
  logic              byte_en;

  rxq_ctrl #(
    .NUM_BUFS(NUM_BUFS), .MSG_BYTES(MSG_BYTES), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rx_we_i),
    .commit_i  (rx_commit_i),
    .abort_i   (rx_abort_i),
    .release_i (host_clr_i),
    .wr_slot_o (wr_slot),
    .byte_idx_o(byte_idx),
    .byte_en_o (byte_en),
    .rd_slot_o (rd_slot),
    .full_o    (rx_full_o),
    .overrun_o (overrun_o)
  );

  rxq_bank #(
    .NUM_BUFS(NUM_BUFS), .MSG_BYTES(MSG_BYTES), .DATA_W(DATA_W),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk_i    (clk_i),
    .we_i     (byte_en),
    .wr_slot_i(wr_slot),
    .wr_idx_i (byte_idx),
    .wdata_i  (rx_wdata_i),
    .rd_en_i  (rx_full_o),
    .rd_slot_i(rd_slot),
    .rd_addr_i(host_addr_i),
    .rdata_o  (host_rdata_o)
  );

  AST_FILL_NOT_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_en && rx_full_o) |-> (wr_slot != rd_slot)); // R3
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_full_o |-> (host_rdata_o == '0)); // R9
  AST_FILL_HOLDS_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_we_i && !rx_commit_i && !rx_abort_i && !host_clr_i) |=> $stable(rd_slot)); // R3
endmodule

// File: tb/rx_msg_queue_tb.sv
`timescale 1ns/1ps
module rx_msg_queue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_we = 1'b0, rx_commit = 1'b0, rx_abort = 1'b0, host_clr = 1'b0;
  logic [7:0] rx_wdata = '0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_rdata;
  logic       rx_full, overrun;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  bit [7:0] qm [4][15];
  int       ql [4];
  int       qcnt = 0;
  bit       ovr = 1'b0;
  bit [7:0] fb [20];

  always #2.5 clk = ~clk;

  rx_msg_queue u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_we_i(rx_we), .rx_wdata_i(rx_wdata),
    .rx_commit_i(rx_commit), .rx_abort_i(rx_abort), .host_addr_i(host_addr),
    .host_rdata_o(host_rdata), .host_clr_i(host_clr), .rx_full_o(rx_full),
    .overrun_o(overrun)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int min15(int n);
    return (n > 15) ? 15 : n;
  endfunction

  task automatic model_push(int len);
    int n = min15(len);
    for (int i = 0; i < n; i++) qm[qcnt][i] = fb[i];
    ql[qcnt] = n;
    qcnt++;
  endtask

  task automatic model_pop();
    for (int j = 0; j < 3; j++) begin
      qm[j] = qm[j + 1];
      ql[j] = ql[j + 1];
    end
    qcnt--;
  endtask

  task automatic check_fg(string req);
    check({req, " full"}, int'(rx_full), int'(qcnt > 0));
    check("R7 overrun", int'(overrun), int'(ovr));
    if (qcnt > 0) begin
      for (int i = 0; i < ql[0]; i++) begin
        host_addr = 4'(i);
        #0.1;
        check({req, " byte"}, int'(host_rdata), int'(qm[0][i]));
      end
    end else begin
      host_addr = 4'd0;
      #0.1;
      check("R9 empty read", int'(host_rdata), 0);
    end
    host_addr = 4'd15;
    #0.1;
    check("R9 addr15", int'(host_rdata), 0);
  endtask

  // kind: 0 commit, 1 discard, 2 discard+commit, 3 commit+release
  task automatic frame(int len, int kind);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_we = 1'b1;
      rx_wdata = fb[i];
    end
    @(negedge clk);
    rx_we = 1'b0;
    check_fg("R3");
    @(negedge clk);
    rx_commit = (kind != 1);
    rx_abort  = (kind == 1 || kind == 2);
    host_clr  = (kind == 3);
    @(negedge clk);
    rx_commit = 1'b0;
    rx_abort = 1'b0;
    host_clr = 1'b0;
    if (kind == 3) begin
      if (qcnt > 0) model_pop();
      model_push(len);
    end else if (kind == 0) begin
      if (qcnt < 4) model_push(len);
      else ovr = 1'b1;
    end
    check_fg(kind == 0 ? "R4" : (kind == 3 ? "R8" : "R5"));
  endtask

  task automatic release_fg();
    @(negedge clk);
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
    if (qcnt > 0) model_pop();
    check_fg("R6");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 full", int'(rx_full), 0);
    check("R1 overrun", int'(overrun), 0);
    for (int a = 0; a < 16; a++) begin
      host_addr = 4'(a);
      #0.1;
      check("R1 read", int'(host_rdata), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_fg("R1");
    // directed
    frame(15, 0);              // R4
    release_fg();              // R6 to empty
    release_fg();              // R6 clear while empty ignored
    frame(6, 1);               // R5 discard
    frame(8, 2);               // R5 discard wins
    frame(3, 0);               // R5 next frame starts at offset 0
    frame(17, 0);              // R2 tail ignored
    frame(1, 0);
    frame(15, 0);              // now 4 stored
    frame(9, 0);               // R7 dropped
    check("R7 overrun set", int'(overrun), 1);
    frame(12, 3);              // R8 swap while full
    for (int k = 0; k < 5; k++) release_fg();
    // random mix
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 9);
      int len = ($urandom_range(0, 7) == 0) ? $urandom_range(16, 17) : $urandom_range(1, 15);
      if (op <= 3)      frame(len, 0);
      else if (op == 4) frame(len, $urandom_range(1, 2));
      else if (op <= 7) release_fg();
      else              frame(len, 3);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule